// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block drives and samples a parameterised number of general-purpose pins, grouped into banks of up to 32 pins each. Software on a 32-bit register bus picks each pin's direction, drives output pins through separate write-one set and write-one clear registers, and reads back the live pin level. Every pin can record rising and/or falling transitions in a sticky status register. Status bits that are unmasked combine into a single interrupt line.

Each bank has the same set of registers at fixed offsets from the bank's base. The first three banks sit 4 bytes apart starting at 0x000. Any further banks sit 4 bytes apart starting at 0x100. Register offsets from a bank's base are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C, status 0x48, interrupt mask 0x9C. Bit k of every register belongs to pin 32*bank + k. Pin inputs go through a two-stage synchroniser before any use.

Top module: `gpio_ctrl`

## Requirements
- R1: A bank with index n < 3 has its base at byte address 4*n. A bank with n >= 3 has its base at 0x100 + 4*(n-3). Register offsets from the base are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C, status 0x48, mask 0x9C.
- R2: Writing the set register raises the output latch bit of each pin whose write-data bit is 1. Writing the clear register lowers it for each such pin. Data bits that are 0 leave the latch as it was. The new value is on pin_out one cycle after the write.
- R3: A direction bit of 1 enables the output driver (pin_oe = 1) and 0 leaves the pin an input. On pins flagged in the DIR_INV parameter the polarity is reversed. The direction register reads back the raw stored bits.
- R4: The level register returns the synchronised pin_in value, whether the pin is an input or an output. A change on pin_in becomes visible in the level register two clock edges later.
- R5: A status bit is set when its synchronised pin rises while its rise-enable bit is 1, or falls while its fall-enable bit is 1. No other transition sets it. The bit is set on the third clock edge after the pin_in change.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new edge event hits the same bit in the same cycle as the clear, the bit stays set.
- R7: irq_o is the registered OR of (status AND mask) over all banks. It follows a change in status or mask by one cycle, so it is high on the fourth edge after a qualifying pin change.
- R8: In a partly populated last bank, bits above the last pin read as 0 in every register, and writes to them are ignored.
- R9: Reads return data one cycle after the address is presented. The set and clear registers and any unmapped address read as zero.
- R10: After reset the output latches, enables, status and masks are 0, and the direction register holds the DIR_INV pattern, so every pin is an input. irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, for the address of the previous cycle |
| pin_in | input | NUM_PINS | Asynchronous pad input levels |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Output driver enables |
| irq_o | output | 1 | Combined masked edge interrupt |

## Verification
Each result has its own fixed latency. Read data, pin_out and pin_oe settle one edge after the access. A pad change shows in the level register after two edges, in status after three, and on irq_o after four. The driver records, with each expected item, the cycle number in which that item is due. The monitor compares items only in that cycle, on the falling edge. For irq_o the bench checks both the cycle just before the event and the cycle of the event, which pins the latency exactly. For the same-cycle clear case, the write is placed so that its clock edge is the one that captures the edge event.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    // bank-relative register offsets
    localparam int unsigned OFF_LVL  = 32'h00;
    localparam int unsigned OFF_DIR  = 32'h0C;
    localparam int unsigned OFF_SET  = 32'h18;
    localparam int unsigned OFF_CLR  = 32'h24;
    localparam int unsigned OFF_RISE = 32'h30;
    localparam int unsigned OFF_FALL = 32'h3C;
    localparam int unsigned OFF_STAT = 32'h48;
    localparam int unsigned OFF_MASK = 32'h9C;

    localparam int unsigned LOW_BANKS  = 3;
    localparam int unsigned HIGH_START = 32'h100;

    function automatic int unsigned bank_base(int unsigned n);
        return (n < LOW_BANKS) ? n * 4 : HIGH_START + (n - LOW_BANKS) * 4;
    endfunction

    typedef struct packed {
        logic [31:0] out;
        logic [31:0] dir;
        logic [31:0] rise;
        logic [31:0] fall;
        logic [31:0] stat;
        logic [31:0] mask;
        logic [31:0] prev;
    } bank_st_t;

    typedef struct packed {
        logic [31:0] rdata;
        logic        irq;
    } top_st_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          NPIN   = 32,
    parameter int unsigned BASE   = 0,
    parameter logic [31:0] INV    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    input  logic [31:0]       lvl_i,
    output logic [NPIN-1:0]   out_o,
    output logic [NPIN-1:0]   oe_o,
    output logic [31:0]       rdata_o,
    output logic              pend_o
);
    localparam logic [31:0] VALID = 32'((33'd1 << NPIN) - 33'd1);
    localparam logic [31:0] INV_V = INV & VALID;

    logic h_lvl, h_dir, h_set, h_clr, h_rise, h_fall, h_stat, h_mask;
    assign h_lvl  = (addr == ADDR_W'(BASE + OFF_LVL));
    assign h_dir  = (addr == ADDR_W'(BASE + OFF_DIR));
    assign h_set  = (addr == ADDR_W'(BASE + OFF_SET));
    assign h_clr  = (addr == ADDR_W'(BASE + OFF_CLR));
    assign h_rise = (addr == ADDR_W'(BASE + OFF_RISE));
    assign h_fall = (addr == ADDR_W'(BASE + OFF_FALL));
    assign h_stat = (addr == ADDR_W'(BASE + OFF_STAT));
    assign h_mask = (addr == ADDR_W'(BASE + OFF_MASK));

    bank_st_t    st_d, st_q;
    logic [31:0] wv, lvl_v, evt, w1c;

    always_comb begin
        wv    = wdata & VALID;
        lvl_v = lvl_i & VALID;
        evt   = ((lvl_v & ~st_q.prev & st_q.rise) |
                 (~lvl_v & st_q.prev & st_q.fall)) & VALID;
        w1c   = (we && h_stat) ? wv : '0;

        st_d      = st_q;
        st_d.prev = lvl_v;
        if (we) begin
            if (h_dir)  st_d.dir  = wv;
            if (h_set)  st_d.out  = st_q.out | wv;
            if (h_clr)  st_d.out  = st_q.out & ~wv;
            if (h_rise) st_d.rise = wv;
            if (h_fall) st_d.fall = wv;
            if (h_mask) st_d.mask = wv;
        end
        // a fresh event outranks a simultaneous clear
        st_d.stat = (st_q.stat & ~w1c) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dir  <= INV_V;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (h_lvl)  rdata_o = lvl_v;
        if (h_dir)  rdata_o = st_q.dir;
        if (h_rise) rdata_o = st_q.rise;
        if (h_fall) rdata_o = st_q.fall;
        if (h_stat) rdata_o = st_q.stat;
        if (h_mask) rdata_o = st_q.mask;
    end

    logic [31:0] oe_full;
    assign oe_full = (st_q.dir ^ INV_V) & VALID;
    assign out_o   = st_q.out[NPIN-1:0];
    assign oe_o    = oe_full[NPIN-1:0];
    assign pend_o  = |(st_q.stat & st_q.mask);
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int                  ADDR_W   = 12,
    parameter int                  NUM_PINS = 112,
    parameter logic [NUM_PINS-1:0] DIR_INV  = NUM_PINS'(64'h0000_0F00_0000_0000)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_o
);
    localparam int NBANK = (NUM_PINS + 31) / 32;

    logic [NUM_PINS-1:0] lvl_sync;
    logic [31:0]         bank_rd   [NBANK];
    logic [NBANK-1:0]    bank_pend;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (lvl_sync)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int          NP   = (b == NBANK - 1) ? NUM_PINS - 32 * b : 32;
        localparam logic [31:0] BINV = 32'(DIR_INV >> (32 * b));

        logic [31:0] lvl_b;
        assign lvl_b = 32'(lvl_sync[32*b +: NP]);

        gpio_bank #(
            .ADDR_W (ADDR_W),
            .NPIN   (NP),
            .BASE   (bank_base(b)),
            .INV    (BINV)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr    (bus_addr),
            .we      (bus_we),
            .wdata   (bus_wdata),
            .lvl_i   (lvl_b),
            .out_o   (pin_out[32*b +: NP]),
            .oe_o    (pin_oe[32*b +: NP]),
            .rdata_o (bank_rd[b]),
            .pend_o  (bank_pend[b])
        );
    end

    top_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        for (int b = 0; b < NBANK; b++) st_d.rdata = st_d.rdata | bank_rd[b];
        st_d.irq   = |bank_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq_o     = st_q.irq;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 112
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic                wd0,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(bank_base(0) + OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(bank_base(0) + OFF_CLR);
    localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'(32'h0F0);

    p_set_pin0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET0 && wd0) |=> pin_out[0]);

    p_clr_pin0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR0 && wd0) |=> !pin_out[0]);

    p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(pin_out));

    p_oe_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(pin_oe));

    p_set_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SET0) |=> (bus_rdata == 32'h0));

    p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_HOLE) |=> (bus_rdata == 32'h0));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .wd0       (bus_wdata[0]),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
    localparam int ADDR_W   = 12;
    localparam int NUM_PINS = 112;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic                bus_we = 1'b0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NUM_PINS-1:0] pin_in, pin_out, pin_oe, ext;
    logic                irq_o;
    logic [127:0]        out_pad, oe_pad;

    // pad model: driven pins loop back, the rest follow the outside world
    assign pin_in  = (pin_oe & pin_out) | (~pin_oe & ext);
    assign out_pad = 128'(pin_out);
    assign oe_pad  = 128'(pin_oe);

    gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    always #10ns clk = ~clk;   // 50 MHz

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 out word, 3 oe word
        int          idx;
        logic [31:0] exp;
        int          due;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each item exactly in its due cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                logic [31:0] act;
                case (q[i].kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, irq_o};
                    2:       act = out_pad[q[i].idx*32 +: 32];
                    default: act = oe_pad[q[i].idx*32 +: 32];
                endcase
                n_chk++;
                if (act !== q[i].exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d idx=%0d cyc=%0d actual=%h expected=%h",
                             q[i].req, q[i].kind, q[i].idx, cyc, act, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    task automatic push(int kind, int idx, logic [31:0] exp, int delay, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.due = cyc + delay; it.req = req;
        q.push_back(it);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_we = 1'b0;
        push(0, 0, exp, 1, req);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin(int i, logic v);
        @(negedge clk);
        ext[i] = v;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=done");
        finish_run();
    end

    initial begin
        ext = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10 reset state
        rd(32'h010, 32'h0000_0F00, "R10 dir reset holds inversion pattern");
        rd(32'h048, 32'h0, "R10 status reset");
        rd(32'h09C, 32'h0, "R10 mask reset");
        push(3, 0, 32'h0, 1, "R10 all inputs bank0");
        push(3, 1, 32'h0, 1, "R10 all inputs bank1 (R3 inverted)");
        push(1, 0, 32'h0, 1, "R10 irq low");
        idle(1);

        // R2 set / clear
        wr(32'h00C, 32'h0000_00FF);
        wr(32'h018, 32'h0000_00A5);
        push(2, 0, 32'h0000_00A5, 1, "R2 set");
        wr(32'h024, 32'h0000_0081);
        push(2, 0, 32'h0000_0024, 1, "R2 clear keeps zero bits");
        rd(32'h018, 32'h0, "R9 set reads zero");
        rd(32'h024, 32'h0, "R9 clear reads zero");

        // R3 direction polarity
        push(3, 0, 32'h0000_00FF, 1, "R3 plain pins");
        wr(32'h010, 32'h0000_0F00);
        push(3, 1, 32'h0, 1, "R3 inverted pins become inputs");
        wr(32'h010, 32'h0000_0003);
        push(3, 1, 32'h0000_0F03, 1, "R3 mixed polarity");
        rd(32'h010, 32'h0000_0003, "R3 raw readback");

        // R4 level register
        @(negedge clk); ext[15:8] = 8'h3C; ext[40] = 1'b1;
        idle(4);
        rd(32'h000, 32'h0000_3C24, "R4 inputs and outputs");
        rd(32'h004, 32'h0, "R4 driven pin overrides pad");
        wr(32'h01C, 32'h0000_0100);
        idle(4);
        rd(32'h004, 32'h0000_0100, "R4 driven high reads back");

        // R1 second group at 0x100
        wr(32'h10C, 32'h0000_0005);
        wr(32'h118, 32'h0000_0004);
        push(3, 3, 32'h0000_0005, 1, "R1 bank3 direction");
        idle(4);
        rd(32'h100, 32'h0000_0004, "R1 bank3 level");
        push(2, 3, 32'h0000_0004, 1, "R1 bank3 latch");

        // R8 partial last bank
        wr(32'h10C, 32'hFFFF_FFFF);
        rd(32'h10C, 32'h0000_FFFF, "R8 dir upper bits");
        push(3, 3, 32'h0000_FFFF, 1, "R8 oe width");
        wr(32'h130, 32'hFFFF_FFFF);
        rd(32'h130, 32'h0000_FFFF, "R8 rise upper bits");
        wr(32'h10C, 32'h0);
        wr(32'h130, 32'h0);

        // R5 edge capture on bank2
        wr(32'h038, 32'h1);
        wr(32'h044, 32'h2);
        wr(32'h0A4, 32'hFFFF_FFFF);
        pin(64, 1'b1);
        push(1, 0, 32'h0, 3, "R7 irq not yet");
        push(1, 0, 32'h1, 4, "R7 irq latency");
        idle(5);
        rd(32'h050, 32'h1, "R5 rise captured");
        pin(65, 1'b1);
        pin(66, 1'b1);
        idle(4);
        rd(32'h050, 32'h1, "R5 disabled edges ignored");
        pin(65, 1'b0);
        idle(4);
        rd(32'h050, 32'h3, "R5 fall captured");

        // R6 write-one-to-clear
        wr(32'h050, 32'h1);
        rd(32'h050, 32'h2, "R6 partial clear");
        pin(64, 1'b0);
        idle(4);
        @(negedge clk); ext[64] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_addr = ADDR_W'(32'h050); bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk); bus_we = 1'b0;
        rd(32'h050, 32'h3, "R6 same-cycle event wins");
        wr(32'h050, 32'hFFFF_FFFF);
        rd(32'h050, 32'h0, "R6 clear all");
        push(1, 0, 32'h0, 1, "R7 irq drops after clear");

        // R7 masking
        wr(32'h0A4, 32'h0);
        pin(64, 1'b0);
        pin(64, 1'b1);
        push(1, 0, 32'h0, 4, "R7 masked event");
        idle(5);
        rd(32'h050, 32'h1, "R7 status still pending");
        wr(32'h0A4, 32'h1);
        push(1, 0, 32'h1, 1, "R7 unmask raises irq");
        wr(32'h050, 32'h1);
        push(1, 0, 32'h0, 1, "R7 clear drops irq");
        idle(1);

        // R7 other bank
        wr(32'h130, 32'h1);
        wr(32'h19C, 32'h1);
        pin(96, 1'b1);
        push(1, 0, 32'h0, 3, "R7 bank3 not yet");
        push(1, 0, 32'h1, 4, "R7 bank3 irq");
        idle(5);
        wr(32'h148, 32'h1);
        push(1, 0, 32'h0, 1, "R7 bank3 clear");
        idle(1);

        // R9 unmapped
        rd(32'h0F0, 32'h0, "R9 hole low group");
        rd(32'h1F0, 32'h0, "R9 hole high group");
        idle(4);

        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard R9 actual=%0d expected=0 pending", q.size());
        end
        finish_run();
    end
endmodule